// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns a pair of quadrature signals into a signed motion count. On every system clock it compares the present level of both inputs with the level seen one clock earlier. It decides whether a counting edge occurred, and whether that edge means forward or reverse travel. A programmable edge-sensitivity mode selects which transitions count: rising edges only, falling edges only, or both. In the last case the resolution is twice that of either single-edge mode. The level of the opposite input at the moment of the edge fixes the direction.

The position register wraps inside a window from zero to a programmable reload value, so one revolution of a rotary encoder can be mapped onto a fixed count range. The block remembers the direction of the most recent step. Whenever a step reverses that direction, it raises one of two sticky flags: one for a reversal to up, one for a reversal to down. Each flag is cleared by a write-one strobe, and the interrupt line is the OR of the two flags. The inputs must already be synchronized to the clock, and they must change no faster than a quarter of the clock rate.

Top module: `quad_position_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `count` = 0, `dir_down` = 0 (up), and `flag_up`, `flag_down` and `irq` all 0.
- R2: With `edge_mode` = 2'b00 (rising only), a rising edge on `in_a` steps down when `in_b` is 1 and up when `in_b` is 0. A rising edge on `in_b` steps up when `in_a` is 1 and down when `in_a` is 0. Falling edges take no step. An input change present at a clock edge updates `count` at that same edge.
- R3: With `edge_mode` = 2'b01 (falling only), a falling edge on `in_a` steps up when `in_b` is 1 and down when `in_b` is 0. A falling edge on `in_b` steps down when `in_a` is 1 and up when `in_a` is 0. Rising edges take no step.
- R4: With `edge_mode` = 2'b10, the rules of R2 and R3 both apply. With `edge_mode` = 2'b11, no edge takes a step.
- R5: When both inputs differ from their values at the previous clock edge, no step is taken.
- R6: An up step from a count equal to or above `reload` gives 0. Any other up step adds 1.
- R7: A down step from 0, or from a count above `reload`, gives `reload`. Any other down step subtracts 1.
- R8: While `en` is 0, edges take no step and are not counted later. The input history keeps tracking, so setting `en` with the inputs still gives no step.
- R9: `dir_down` shows the direction of the last step (1 = down). A down-to-up reversal sets `flag_up`, and an up-to-down reversal sets `flag_down`. The remembered direction starts at up, so the first up step sets no flag.
- R10: A 1 on `clr_up` or `clr_down` clears its flag at the next edge. If a reversal sets the same flag in that cycle, the set wins.
- R11: `irq` equals `flag_up` OR `flag_down`, updated at the same edge as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Counting enable |
| in_a | input | 1 | Quadrature input A, synchronized |
| in_b | input | 1 | Quadrature input B, synchronized |
| edge_mode | input | 2 | 00 rising, 01 falling, 10 both, 11 none |
| reload | input | W | Top of the count window |
| clr_up | input | 1 | Write-one clear of `flag_up` |
| clr_down | input | 1 | Write-one clear of `flag_down` |
| count | output | W | Position count |
| dir_down | output | 1 | Direction of last step, 1 = down |
| flag_up | output | 1 | Sticky down-to-up reversal flag |
| flag_down | output | 1 | Sticky up-to-down reversal flag |
| irq | output | 1 | OR of the two flags |

## Verification
A wrong step decision shows on `count` at the very edge that samples the input change, so every stimulus cycle is compared against a model right after that edge. A stale input history or a wrong remembered direction stays hidden until the next edge or reversal. At that point it appears as a missing or extra step, or as a flag that fails to rise or rises when it should not. For that reason the sweep walks every start state, every single-input and dual-input transition, and every mode. A wrap fault appears only at the window ends, so dedicated runs cross both ends several times with a small reload value.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10
  } step_e;
endpackage

// File: rtl/qpc_edge_decode.sv
module qpc_edge_decode
  import qpc_pkg::*;
(
  input  logic       clk,
  input  logic       en,
  input  logic       in_a,
  input  logic       in_b,
  input  edge_mode_e mode,
  output step_e      step
);
  logic prev_a, prev_b;

  // History tracks the inputs in every cycle, reset and disable included,
  // so no stale edge appears when counting resumes.
  always_ff @(posedge clk) begin
    prev_a <= in_a;
    prev_b <= in_b;
  end

  logic rise_a, fall_a, rise_b, fall_b, both_moved;
  logic use_rise, use_fall;

  always_comb begin
    rise_a     = in_a & ~prev_a;
    fall_a     = ~in_a & prev_a;
    rise_b     = in_b & ~prev_b;
    fall_b     = ~in_b & prev_b;
    both_moved = (in_a ^ prev_a) & (in_b ^ prev_b);
    use_rise   = (mode == EDGE_RISE) || (mode == EDGE_BOTH);
    use_fall   = (mode == EDGE_FALL) || (mode == EDGE_BOTH);
    step       = STEP_HOLD;
    if (en && !both_moved) begin
      if (use_rise && rise_a) step = in_b ? STEP_DOWN : STEP_UP;
      if (use_rise && rise_b) step = in_a ? STEP_UP   : STEP_DOWN;
      if (use_fall && fall_a) step = in_b ? STEP_UP   : STEP_DOWN;
      if (use_fall && fall_b) step = in_a ? STEP_DOWN : STEP_UP;
    end
  end
endmodule

// File: rtl/qpc_wrap_counter.sv
module qpc_wrap_counter
  import qpc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  step_e        step,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  logic at_top, at_bottom;

  always_comb begin
    at_top    = (count >= reload);
    at_bottom = (count == ZERO) || (count > reload);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= ZERO;
    end else begin
      unique case (step)
        STEP_UP:   count <= at_top    ? ZERO   : count + ONE;
        STEP_DOWN: count <= at_bottom ? reload : count - ONE;
        default:   count <= count;
      endcase
    end
  end
endmodule

// File: rtl/qpc_dir_tracker.sv
module qpc_dir_tracker
  import qpc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  step_e step,
  input  logic  clr_up,
  input  logic  clr_down,
  output logic  dir_down,
  output logic  flag_up,
  output logic  flag_down,
  output logic  irq
);
  logic set_up, set_down, nxt_up, nxt_down;

  always_comb begin
    set_up   = (step == STEP_UP)   &&  dir_down;
    set_down = (step == STEP_DOWN) && !dir_down;
    nxt_up   = set_up   | (flag_up   & ~clr_up);
    nxt_down = set_down | (flag_down & ~clr_down);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_down  <= 1'b0;
      flag_up   <= 1'b0;
      flag_down <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (step == STEP_UP)   dir_down <= 1'b0;
      if (step == STEP_DOWN) dir_down <= 1'b1;
      flag_up   <= nxt_up;
      flag_down <= nxt_down;
      irq       <= nxt_up | nxt_down;
    end
  end
endmodule

// File: rtl/quad_position_counter.sv
module quad_position_counter
  import qpc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         in_a,
  input  logic         in_b,
  input  logic [1:0]   edge_mode,
  input  logic [W-1:0] reload,
  input  logic         clr_up,
  input  logic         clr_down,
  output logic [W-1:0] count,
  output logic         dir_down,
  output logic         flag_up,
  output logic         flag_down,
  output logic         irq
);
  step_e step;

  qpc_edge_decode u_decode (
    .clk  (clk),
    .en   (en),
    .in_a (in_a),
    .in_b (in_b),
    .mode (edge_mode_e'(edge_mode)),
    .step (step)
  );

  qpc_wrap_counter #(.W(W)) u_counter (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .reload (reload),
    .count  (count)
  );

  qpc_dir_tracker u_dir (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .clr_up    (clr_up),
    .clr_down  (clr_down),
    .dir_down  (dir_down),
    .flag_up   (flag_up),
    .flag_down (flag_down),
    .irq       (irq)
  );
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         in_a,
  input logic         in_b,
  input logic [W-1:0] reload,
  input logic [W-1:0] count,
  input logic         dir_down,
  input logic         flag_up,
  input logic         flag_down,
  input logic         irq
);
  localparam logic [W-1:0] ONE = W'(1);
  logic pv;

  always_ff @(posedge clk) pv <= !rst;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (count == '0) && !dir_down && !flag_up && !flag_down && !irq);

  // R5
  dual_change_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pv && (in_a != $past(in_a)) && (in_b != $past(in_b)) |=> $stable(count));

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pv && !en |=> $stable(count));

  // R6
  single_move_chk: assert property (@(posedge clk) disable iff (rst)
    pv |-> (count == $past(count)) || (count == $past(count) + ONE) ||
           (count == $past(count) - ONE) || (count == '0) || (count == $past(reload)));

  // R9
  up_flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    pv && $rose(flag_up) |-> !dir_down && $past(dir_down));

  // R9
  down_flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    pv && $rose(flag_down) |-> dir_down && !$past(dir_down));

  // R11
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    pv |-> irq == (flag_up | flag_down));
endmodule

bind quad_position_counter qpc_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .in_a      (in_a),
  .in_b      (in_b),
  .reload    (reload),
  .count     (count),
  .dir_down  (dir_down),
  .flag_up   (flag_up),
  .flag_down (flag_down),
  .irq       (irq)
);

// File: tb/quad_position_counter_tb.sv
`timescale 1ns/1ps
module quad_position_counter_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         in_a = 1'b0, in_b = 1'b0;
  logic [1:0]   edge_mode = 2'b10;
  logic [W-1:0] reload = W'(5);
  logic         clr_up = 1'b0, clr_down = 1'b0;
  logic [W-1:0] count;
  logic         dir_down, flag_up, flag_down, irq;

  int checks = 0;
  int errors = 0;

  int   m_cnt = 0;
  logic m_dir = 1'b0, m_fu = 1'b0, m_fd = 1'b0;
  logic m_a = 1'b0, m_b = 1'b0;

  always #2.5 clk = ~clk;

  quad_position_counter #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .en(en), .in_a(in_a), .in_b(in_b),
    .edge_mode(edge_mode), .reload(reload), .clr_up(clr_up), .clr_down(clr_down),
    .count(count), .dir_down(dir_down), .flag_up(flag_up),
    .flag_down(flag_down), .irq(irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Drives one cycle of stimulus and checks against a requirement model.
  task automatic apply(input logic a, input logic b, input logic e,
                       input logic cu, input logic cd, input string tag);
    int  st;
    logic ur, uf, su, sd;
    @(negedge clk);
    in_a = a; in_b = b; en = e; clr_up = cu; clr_down = cd;
    st = 0; su = 1'b0; sd = 1'b0;
    ur = (edge_mode == 2'b00) || (edge_mode == 2'b10);
    uf = (edge_mode == 2'b01) || (edge_mode == 2'b10);
    if (e && !((a != m_a) && (b != m_b))) begin
      if (ur && a && !m_a) st = b ? 2 : 1;
      if (ur && b && !m_b) st = a ? 1 : 2;
      if (uf && !a && m_a) st = b ? 1 : 2;
      if (uf && !b && m_b) st = a ? 2 : 1;
    end
    m_a = a; m_b = b;
    if (st == 1) begin
      m_cnt = (m_cnt >= int'(reload)) ? 0 : m_cnt + 1;
      su = m_dir; m_dir = 1'b0;
    end else if (st == 2) begin
      m_cnt = (m_cnt == 0 || m_cnt > int'(reload)) ? int'(reload) : m_cnt - 1;
      sd = !m_dir; m_dir = 1'b1;
    end
    m_fu = su | (m_fu & !cu);
    m_fd = sd | (m_fd & !cd);
    @(posedge clk); #1;
    chk(tag, int'(count), m_cnt);
    chk({tag, " R9 dir/flags"}, int'({dir_down, flag_up, flag_down}),
        int'({m_dir, m_fu, m_fd}));
    chk({tag, " R11 irq"}, int'(irq), int'(m_fu | m_fd));
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired got 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] up_seq [4];
    logic [1:0] dn_seq [4];
    up_seq[0] = 2'b10; up_seq[1] = 2'b11; up_seq[2] = 2'b01; up_seq[3] = 2'b00;
    dn_seq[0] = 2'b01; dn_seq[1] = 2'b11; dn_seq[2] = 2'b10; dn_seq[3] = 2'b00;

    repeat (3) @(posedge clk);
    #1;
    chk("R1 count", int'(count), 0);
    chk("R1 dir/flags/irq", int'({dir_down, flag_up, flag_down, irq}), 0);
    @(negedge clk);
    rst = 1'b0;

    // Sweep every mode, start state and transition kind.
    for (int m = 0; m < 4; m++) begin
      edge_mode = 2'(m);
      for (int s = 0; s < 4; s++) begin
        for (int t = 0; t < 3; t++) begin
          string tag;
          logic sa, sb, na, nb;
          tag = (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
          sa = s[1]; sb = s[0];
          na = sa ^ (t != 1);
          nb = sb ^ (t != 0);
          apply(sa, sb, 1'b1, 1'b0, 1'b0, tag);
          apply(na, nb, 1'b1, 1'b0, 1'b0, (t == 2) ? "R5" : tag);
          apply(sa, sb, 1'b1, 1'b0, 1'b0, tag);
        end
      end
    end

    // Wrap at both ends of a small window.
    edge_mode = 2'b10;
    reload = W'(3);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 12; i++)
      apply(up_seq[i % 4][1], up_seq[i % 4][0], 1'b1, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 12; i++)
      apply(dn_seq[i % 4][1], dn_seq[i % 4][0], 1'b1, 1'b0, 1'b0, "R7");

    // Disabled counting: edges are dropped, not deferred.
    for (int i = 0; i < 3; i++)
      apply(up_seq[i][1], up_seq[i][0], 1'b0, 1'b0, 1'b0, "R8");
    apply(up_seq[2][1], up_seq[2][0], 1'b1, 1'b0, 1'b0, "R8");
    apply(up_seq[2][1], up_seq[2][0], 1'b1, 1'b0, 1'b0, "R8");

    // Flag clearing, then set winning over a same-cycle clear.
    apply(up_seq[2][1], up_seq[2][0], 1'b1, 1'b1, 1'b1, "R10");
    chk("R10 flags cleared", int'({flag_up, flag_down}), 0);
    apply(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R10");   // 01->11 down
    apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R10");   // 11->01 up with clear
    chk("R10 set wins", int'(flag_up), 1);
    apply(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R10");
    chk("R10 both cleared", int'(irq), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule